// File: doc/BRIEF.md
# Timer Microengine Special Register Bank

This block keeps the special-purpose registers of a small timer-channel microengine and applies the side effects tied to them. It contains two 24-bit event registers (A and B), a 24-bit shift register, an 8-bit link command register that can only be written, and a 14-bit return address register. Each register can be written by the ALU through a register-select code. Several of them also change on events: the start of a thread, a write to the channel-select register, a match-register read, a subroutine call, a shift command, or test mode.

The event registers supply the data for match-register writes and for the up/down counter match write. The shift register takes in the bit that the post-ALU shifter drops, so together they form a 48-bit right shift. A write to the link register sends out a one-cycle service request that carries an engine select and a channel number. The return address register saves the PC on a call and drives the PC reload bus on a return.

Top module: `tmr_spreg_bank`

## Requirements
- R1: After reset, event A, event B, the shift register, link_req, link_engine and link_chan are all zero, and the return address register holds 0x3FFF.
- R2: When thread_start or chan_sel_wr is high at a clock edge, event A takes cap_a and event B takes cap_b. This load wins over a match read and over an ALU write to the same register.
- R3: mrd_a loads event A from match_a and mrd_b loads event B from match_b. A match read wins over an ALU write to the same register.
- R4: When wr_en is high, wr_data is written into the register named by wr_sel. The codes are 0 = event A, 1 = event B, 2 = shift, 3 = link and 4 = return address (which takes the low 14 bits). rd_sel selects rd_data with the same codes, and the return address is zero-extended.
- R5: mwr_data is event A when mwr_src is 0 and event B when mwr_src is 1. udcm_data is always event A.
- R6: When shift_en is high, the shift register becomes {shift_in, shift[23:1]}. An ALU write to the shift register in the same cycle wins.
- R7: A write to code 3 sets link_req high for exactly the next cycle. link_engine takes bit 7 of the written value and link_chan takes bits 6:0. Reading code 3 returns zero.
- R8: call_en loads the return address register from pc_in. A call wins over an ALU write to code 4.
- R9: pc_reload always shows the return address register, and pc_reload_vld follows ret_en in the same cycle.
- R10: While test_mode is high, the return address register is loaded with 0x3FFF. This wins over a call and over an ALU write.
- R11: Writes with codes 5, 6 and 7 change no register, and reads with those codes return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | ALU write strobe |
| wr_sel | input | 3 | ALU destination register code |
| wr_data | input | 24 | ALU result |
| rd_sel | input | 3 | ALU source register code |
| rd_data | output | 24 | Read data for the selected register |
| thread_start | input | 1 | A thread begins executing |
| chan_sel_wr | input | 1 | The channel-select register is written |
| cap_a | input | 24 | CaptureA of the current channel |
| cap_b | input | 24 | CaptureB of the current channel |
| mrd_a | input | 1 | Read MatchA into event A |
| mrd_b | input | 1 | Read MatchB into event B |
| match_a | input | 24 | MatchA of the current channel |
| match_b | input | 24 | MatchB of the current channel |
| mwr_src | input | 1 | Source of the match write data (0 = A, 1 = B) |
| mwr_data | output | 24 | Match register write data |
| udcm_data | output | 24 | Up/down counter match write data |
| shift_en | input | 1 | Shift command |
| shift_in | input | 1 | Bit dropped by the post-ALU shifter |
| link_req | output | 1 | One-cycle link service request |
| link_engine | output | 1 | Engine select of the request |
| link_chan | output | 7 | Channel number of the request |
| call_en | input | 1 | Subroutine call |
| pc_in | input | 14 | Current PC |
| ret_en | input | 1 | Return from subroutine |
| pc_reload | output | 14 | PC reload value |
| pc_reload_vld | output | 1 | PC reload strobe |
| test_mode | input | 1 | Test mode |

## Verification
Most of the risk lies in events that reach the same register in the same cycle. The bench starts a thread or selects a channel in the same cycle as a match read and an ALU write to that event register. It also issues a call together with an ALU write to the return address register while test mode is both high and low, and it writes the shift register during a shift. In each case it reads the register back through rd_sel one cycle later and compares it with the value of the event that has the highest priority.

// File: rtl/tmr_spreg_pkg.sv
package tmr_spreg_pkg;
    // Register select codes shared by the write and read ports
    typedef enum logic [2:0] {
        RS_EVA = 3'd0,
        RS_EVB = 3'd1,
        RS_SHF = 3'd2,
        RS_LNK = 3'd3,
        RS_RET = 3'd4
    } rsel_e;
endpackage

// File: rtl/tmr_evreg.sv
module tmr_evreg #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_evt,
    input  logic [DW-1:0] cap,
    input  logic          mrd,
    input  logic [DW-1:0] match,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (load_evt) q <= cap;
        else if (mrd)      q <= match;
        else if (wr)       q <= wdata;
    end

    p_evload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> q == $past(cap));
    p_mrd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_evt && mrd) |=> q == $past(match));
endmodule

// File: rtl/tmr_shreg.sv
module tmr_shreg #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          shift_en,
    input  logic          shift_in,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (wr)       q <= wdata;
        else if (shift_en) q <= {shift_in, q[DW-1:1]};
    end

    p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !wr) |=> q == {$past(shift_in), $past(q[DW-1:1])});
endmodule

// File: rtl/tmr_lnkreg.sv
module tmr_lnkreg #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [LW-1:0] wdata,
    output logic          req,
    output logic          engine,
    output logic [LW-2:0] chan
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req    <= 1'b0;
            engine <= 1'b0;
            chan   <= '0;
        end else begin
            req <= wr;
            if (wr) begin
                engine <= wdata[LW-1];
                chan   <= wdata[LW-2:0];
            end
        end
    end

    p_link_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> req && engine == $past(wdata[LW-1]) && chan == $past(wdata[LW-2:0]));
    p_link_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr) |=> !req);
endmodule

// File: rtl/tmr_retreg.sv
module tmr_retreg #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    input  logic          call,
    input  logic [AW-1:0] pc_in,
    input  logic          wr,
    input  logic [AW-1:0] wdata,
    input  logic          ret_en,
    output logic [AW-1:0] q,
    output logic [AW-1:0] pc_reload,
    output logic          pc_reload_vld
);
    localparam logic [AW-1:0] PARK = {AW{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)         q <= PARK;
        else if (test_mode) q <= PARK;
        else if (call)      q <= pc_in;
        else if (wr)        q <= wdata;
    end

    always_comb begin
        pc_reload     = q;
        pc_reload_vld = ret_en;
    end

    p_test_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> q == PARK);
    p_call_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (call && !test_mode) |=> q == $past(pc_in));
endmodule

// File: rtl/tmr_spreg_bank.sv
module tmr_spreg_bank
    import tmr_spreg_pkg::*;
#(
    parameter int DW = 24,
    parameter int LW = 8,
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    input  logic          thread_start,
    input  logic          chan_sel_wr,
    input  logic [DW-1:0] cap_a,
    input  logic [DW-1:0] cap_b,
    input  logic          mrd_a,
    input  logic          mrd_b,
    input  logic [DW-1:0] match_a,
    input  logic [DW-1:0] match_b,
    input  logic          mwr_src,
    output logic [DW-1:0] mwr_data,
    output logic [DW-1:0] udcm_data,
    input  logic          shift_en,
    input  logic          shift_in,
    output logic          link_req,
    output logic          link_engine,
    output logic [LW-2:0] link_chan,
    input  logic          call_en,
    input  logic [AW-1:0] pc_in,
    input  logic          ret_en,
    output logic [AW-1:0] pc_reload,
    output logic          pc_reload_vld,
    input  logic          test_mode
);
    localparam int NEV = 2;

    logic [DW-1:0] ev_cap [NEV];
    logic [DW-1:0] ev_mat [NEV];
    logic          ev_mrd [NEV];
    logic          ev_wr  [NEV];
    logic [DW-1:0] ev_q   [NEV];
    logic          load_evt;
    logic [DW-1:0] shf_q;
    logic [AW-1:0] ret_q;

    assign load_evt = thread_start | chan_sel_wr;

    always_comb begin
        ev_cap[0] = cap_a;   ev_cap[1] = cap_b;
        ev_mat[0] = match_a; ev_mat[1] = match_b;
        ev_mrd[0] = mrd_a;   ev_mrd[1] = mrd_b;
        ev_wr[0]  = wr_en && (wr_sel == RS_EVA);
        ev_wr[1]  = wr_en && (wr_sel == RS_EVB);
    end

    for (genvar g = 0; g < NEV; g++) begin : g_ev
        tmr_evreg #(.DW(DW)) i_ev (
            .clk(clk), .rst_n(rst_n), .load_evt(load_evt),
            .cap(ev_cap[g]), .mrd(ev_mrd[g]), .match(ev_mat[g]),
            .wr(ev_wr[g]), .wdata(wr_data), .q(ev_q[g])
        );
    end

    tmr_shreg #(.DW(DW)) i_shf (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_en && (wr_sel == RS_SHF)), .wdata(wr_data),
        .shift_en(shift_en), .shift_in(shift_in), .q(shf_q)
    );

    tmr_lnkreg #(.LW(LW)) i_lnk (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_en && (wr_sel == RS_LNK)), .wdata(wr_data[LW-1:0]),
        .req(link_req), .engine(link_engine), .chan(link_chan)
    );

    tmr_retreg #(.AW(AW)) i_ret (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .call(call_en), .pc_in(pc_in),
        .wr(wr_en && (wr_sel == RS_RET)), .wdata(wr_data[AW-1:0]),
        .ret_en(ret_en), .q(ret_q),
        .pc_reload(pc_reload), .pc_reload_vld(pc_reload_vld)
    );

    always_comb begin
        case (rd_sel)
            RS_EVA:  rd_data = ev_q[0];
            RS_EVB:  rd_data = ev_q[1];
            RS_SHF:  rd_data = shf_q;
            RS_RET:  rd_data = {{(DW-AW){1'b0}}, ret_q};
            default: rd_data = '0;
        endcase
        mwr_data  = mwr_src ? ev_q[1] : ev_q[0];
        udcm_data = ev_q[0];
    end

    p_mwr_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_b && !load_evt && !mwr_src) |=> ##0 (mwr_src || mwr_data == udcm_data));
endmodule

// File: tb/test_tmr_spreg_bank.sv
module test_tmr_spreg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, thread_start = 0, chan_sel_wr = 0, mrd_a = 0, mrd_b = 0;
    logic        mwr_src = 0, shift_en = 0, shift_in = 0, call_en = 0, ret_en = 0, test_mode = 0;
    logic [2:0]  wr_sel = 0, rd_sel = 0;
    logic [23:0] wr_data = 0, cap_a = 0, cap_b = 0, match_a = 0, match_b = 0;
    logic [13:0] pc_in = 0;
    logic [23:0] rd_data, mwr_data, udcm_data;
    logic        link_req, link_engine, pc_reload_vld;
    logic [6:0]  link_chan;
    logic [13:0] pc_reload;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tmr_spreg_bank i_tmr_spreg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .thread_start(thread_start),
        .chan_sel_wr(chan_sel_wr), .cap_a(cap_a), .cap_b(cap_b), .mrd_a(mrd_a),
        .mrd_b(mrd_b), .match_a(match_a), .match_b(match_b), .mwr_src(mwr_src),
        .mwr_data(mwr_data), .udcm_data(udcm_data), .shift_en(shift_en),
        .shift_in(shift_in), .link_req(link_req), .link_engine(link_engine),
        .link_chan(link_chan), .call_en(call_en), .pc_in(pc_in), .ret_en(ret_en),
        .pc_reload(pc_reload), .pc_reload_vld(pc_reload_vld), .test_mode(test_mode)
    );

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic rd(string req, logic [2:0] s, logic [23:0] exp);
        rd_sel = s;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic alu_wr(logic [2:0] s, logic [23:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [23:0] pat [5];
        logic [23:0] exp_s;
        pat[0] = 24'h000000; pat[1] = 24'hFFFFFF; pat[2] = 24'hA5C3E1;
        pat[3] = 24'h5A3C1E; pat[4] = 24'h800081;
        repeat (3) tick();
        rst_n = 1;
        // R1 reset state
        rd("R1", 3'd0, 24'h0); rd("R1", 3'd1, 24'h0); rd("R1", 3'd2, 24'h0);
        rd("R1", 3'd4, 24'h003FFF);
        check("R1", {21'h0, link_req, link_engine, 1'b0}, 24'h0);
        check("R1", {17'h0, link_chan}, 24'h0);

        // R4 write/read sweep over codes and patterns
        for (int p = 0; p < 5; p++) begin
            for (int s = 0; s < 5; s++) begin
                if (s != 3) begin
                    alu_wr(3'(s), pat[p]);
                    rd("R4", 3'(s), (s == 4) ? {10'h0, pat[p][13:0]} : pat[p]);
                end
            end
        end

        // R11 unused codes
        alu_wr(3'd0, 24'h111111); alu_wr(3'd1, 24'h222222);
        alu_wr(3'd2, 24'h333333); alu_wr(3'd4, 24'h001234);
        for (int s = 5; s < 8; s++) begin
            alu_wr(3'(s), 24'hFFFFFF);
            rd("R11", 3'(s), 24'h0);
        end
        rd("R11", 3'd0, 24'h111111); rd("R11", 3'd1, 24'h222222);
        rd("R11", 3'd2, 24'h333333); rd("R11", 3'd4, 24'h001234);
        check("R11", {23'h0, link_req}, 24'h0);

        // R2 event load with competing match read and ALU write
        for (int k = 0; k < 8; k++) begin
            cap_a = 24'h010203 * (k + 1); cap_b = 24'hF0E0D0 ^ (24'h1111 * k);
            match_a = 24'hDEAD00; match_b = 24'hBEEF00;
            mrd_a = k[0]; mrd_b = k[1];
            thread_start = !k[2]; chan_sel_wr = k[2];
            wr_en = 1; wr_sel = 3'(k % 2); wr_data = 24'h777777;
            tick();
            thread_start = 0; chan_sel_wr = 0; mrd_a = 0; mrd_b = 0; wr_en = 0;
            rd("R2", 3'd0, 24'h010203 * (k + 1));
            rd("R2", 3'd1, 24'hF0E0D0 ^ (24'h1111 * k));
        end

        // R3 match read beats ALU write
        match_a = 24'h13579B; mrd_a = 1; wr_en = 1; wr_sel = 3'd0; wr_data = 24'h999999;
        tick(); mrd_a = 0; wr_en = 0;
        rd("R3", 3'd0, 24'h13579B);
        match_b = 24'h2468AC; mrd_b = 1;
        tick(); mrd_b = 0;
        rd("R3", 3'd1, 24'h2468AC);
        rd("R3", 3'd0, 24'h13579B);

        // R5 match write data source
        mwr_src = 0; #1; check("R5", mwr_data, 24'h13579B);
        mwr_src = 1; #1; check("R5", mwr_data, 24'h2468AC);
        check("R5", udcm_data, 24'h13579B);
        mwr_src = 0;

        // R6 48-bit shift chain
        exp_s = 24'hC0FFEE;
        alu_wr(3'd2, exp_s);
        for (int i = 0; i < 48; i++) begin
            shift_en = 1; shift_in = ((24'h9B3D57 >> (i % 24)) & 1) != 0;
            exp_s = {shift_in, exp_s[23:1]};
            tick();
            rd("R6", 3'd2, exp_s);
        end
        wr_en = 1; wr_sel = 3'd2; wr_data = 24'h0F0F0F; shift_in = 1;
        tick(); wr_en = 0; shift_en = 0;
        rd("R6", 3'd2, 24'h0F0F0F);

        // R7 link request pulse
        for (int v = 0; v < 4; v++) begin
            logic [7:0] lv;
            lv = (v == 0) ? 8'h85 : (v == 1) ? 8'h7F : (v == 2) ? 8'hFF : 8'h00;
            alu_wr(3'd3, {16'hABCD, lv});
            check("R7", {23'h0, link_req}, 24'h1);
            check("R7", {16'h0, link_engine, link_chan}, {16'h0, lv});
            rd("R7", 3'd3, 24'h0);
            tick();
            check("R7", {23'h0, link_req}, 24'h0);
        end

        // R8 call beats ALU write
        for (int c = 0; c < 4; c++) begin
            call_en = 1; pc_in = 14'(14'h0123 * (c + 3));
            wr_en = 1; wr_sel = 3'd4; wr_data = 24'h002222;
            tick(); call_en = 0; wr_en = 0;
            rd("R8", 3'd4, {10'h0, 14'(14'h0123 * (c + 3))});
        end

        // R9 return drives reload bus in the same cycle
        ret_en = 1; #1;
        check("R9", {23'h0, pc_reload_vld}, 24'h1);
        check("R9", {10'h0, pc_reload}, {10'h0, 14'(14'h0123 * 6)});
        ret_en = 0; #1;
        check("R9", {23'h0, pc_reload_vld}, 24'h0);

        // R10 test mode beats call and write
        alu_wr(3'd4, 24'h000042);
        test_mode = 1; call_en = 1; pc_in = 14'h0ABC;
        wr_en = 1; wr_sel = 3'd4; wr_data = 24'h000055;
        tick(); call_en = 0; wr_en = 0;
        rd("R10", 3'd4, 24'h003FFF);
        check("R10", {10'h0, pc_reload}, 24'h003FFF);
        test_mode = 0;
        call_en = 1; pc_in = 14'h0ABC; tick(); call_en = 0;
        rd("R8", 3'd4, 24'h000ABC);

        report();
    end
endmodule